// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It looks at the line once per sample tick, with sixteen ticks to one bit period. A falling edge on an idle line opens a candidate start bit. The candidate is kept only if a majority vote over its eighth, ninth and tenth samples reads low. Every later bit is decided by the same three-sample vote near its centre. Bits arrive least significant first. They are collected in a shift register and moved into a single-entry holding buffer once the first stop bit has been decided.

The holding buffer keeps the character together with its own frame, parity and overrun flags. A full flag tells the consumer that an unread character is waiting. A one-cycle read strobe empties the buffer and clears its flags. Dropping the receive enable discards everything the buffer holds and returns the receiver to hunting for a start edge. Before any edge detection, the incoming line passes through a two-flop synchronizer.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `full`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: `len_code` selects the character length: codes 0, 1, 2, 3 give 5, 6, 7, 8 data bits, and codes 4 to 7 give 9. The first received data bit lands in `rd_data[0]`. Bits above the character length read 0. The ninth data bit appears on `rd_ext`.
- R3: A low pulse that starts from an idle line but whose samples 8, 9 and 10 vote high is rejected. Nothing is stored, and the next valid frame is received correctly.
- R4: A disturbance that flips only one of the three centre samples of a bit does not change the decided value of that bit.
- R5: `par_mode[1]`=1 enables a parity bit after the data, and `par_mode[0]` selects odd (1) or even (0). `err_parity` is 1 for a stored character whose parity bit does not match the parity of its data bits. With `par_mode[1]`=0, no parity bit is expected.
- R6: `err_frame` is 1 when the first stop bit is decided low. With `two_stop`=1, the level of the second stop bit has no effect on any flag.
- R7: `full` rises when a character is stored and stays high until a `rd_pulse` cycle. `full` reads 0 on the cycle after that read.
- R8: If a start bit is accepted while the buffer holds unread data, `err_overrun` becomes 1, the buffered character is kept and the new character is discarded. A read clears `err_overrun`.
- R9: The error flags describe only the buffered character. They are 0 whenever `full` is 0, and a clean character that follows an erroneous one shows no flags.
- R10: While `rx_on` is 0, the buffer is flushed (`full` and all flags are 0 on the next cycle) and line activity is not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rx_line | input | 1 | Serial line, idle high |
| rx_on | input | 1 | Receive enable; low flushes the buffer |
| len_code | input | 3 | Character length code |
| par_mode | input | 2 | [1] parity enable, [0] odd parity |
| two_stop | input | 1 | Frame carries a second stop bit |
| rd_pulse | input | 1 | Read strobe, empties the buffer |
| rd_data | output | 8 | Buffered data bits 0 to 7 |
| rd_ext | output | 1 | Buffered ninth data bit |
| full | output | 1 | Unread character present |
| err_frame | output | 1 | Buffered character had a low first stop bit |
| err_parity | output | 1 | Buffered character failed its parity check |
| err_overrun | output | 1 | A start arrived while the buffer was full |

## Verification
The bench uses the default parameters: sixteen samples per bit, votes on samples 8 to 10, and lengths from 5 to 9 bits. It issues one sample tick every four clocks, so a bit lasts 64 clocks. With that spacing, a one-tick disturbance hits exactly one sample, and a six-tick low pulse ends well before the vote window. Both the single-sample vote case and the rejected-start case can therefore be placed deliberately. Every length code, both parity senses, both stop-bit counts, overrun and flush are driven through the real serial timing.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } srx_state_e;

  localparam int PAR_EN_BIT  = 1;
  localparam int PAR_ODD_BIT = 0;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int VOTE_FIRST = 8,
  localparam int CNTW      = $clog2(OSR + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  input  logic enable,
  input  logic hunting,
  output logic edge_evt,
  output logic decide_evt,
  output logic bit_val
);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(OSR);
  localparam logic [CNTW-1:0] ONE_C  = CNTW'(1);
  localparam logic [CNTW-1:0] VA_C   = CNTW'(VOTE_FIRST);
  localparam logic [CNTW-1:0] VB_C   = CNTW'(VOTE_FIRST + 1);
  localparam logic [CNTW-1:0] VC_C   = CNTW'(VOTE_FIRST + 2);

  logic            prev_s;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] idx_now;
  logic            samp_a, samp_b;
  logic            busy_tick;

  // index of the sample being taken on this tick, 1..OSR
  always_comb idx_now = (cnt_q == LAST_C) ? ONE_C : cnt_q + ONE_C;

  assign busy_tick  = enable & ~hunting & tick;
  assign edge_evt   = enable & hunting & tick & prev_s & ~line_s;
  assign decide_evt = busy_tick & (idx_now == VC_C);
  assign bit_val    = vote3(samp_a, samp_b, line_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= 1'b1;
      cnt_q  <= '0;
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else begin
      if (tick) prev_s <= line_s;
      if (edge_evt)       cnt_q <= ONE_C;
      else if (busy_tick) cnt_q <= idx_now;
      if (busy_tick && idx_now == VA_C) samp_a <= line_s;
      if (busy_tick && idx_now == VB_C) samp_b <= line_s;
    end
  end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int  MIN_BITS = 5,
  parameter int  MAX_BITS = 9,
  parameter int  LENW     = 3,
  localparam int IDXW     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                edge_evt,
  input  logic                decide_evt,
  input  logic                bit_val,
  input  logic [LENW-1:0]     len_code,
  input  logic                par_on,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                buf_full,
  input  logic                rd_pulse,
  output logic                hunting,
  output logic                start_ok,
  output logic                store_evt,
  output logic [MAX_BITS-1:0] frm_data,
  output logic                frm_ferr,
  output logic                frm_perr
);
  function automatic logic [IDXW-1:0] bits_for(input logic [LENW-1:0] code);
    if (int'(code) >= MAX_BITS - MIN_BITS) return IDXW'(MAX_BITS);
    return IDXW'(MIN_BITS + int'(code));
  endfunction

  function automatic logic [MAX_BITS-1:0] align_right(input logic [MAX_BITS-1:0] sh,
                                                      input logic [IDXW-1:0] n);
    return sh >> (MAX_BITS - int'(n));
  endfunction

  function automatic logic parity_of(input logic [MAX_BITS-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  srx_state_e          state_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic [IDXW-1:0]     got_q, nbits_q;
  logic                par_q, odd_q, two_q, pbit_q, drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      shreg_q <= '0;
      got_q   <= '0;
      nbits_q <= IDXW'(MAX_BITS);
      par_q   <= 1'b0;
      odd_q   <= 1'b0;
      two_q   <= 1'b0;
      pbit_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else if (!enable) begin
      state_q <= ST_HUNT;
    end else begin
      case (state_q)
        ST_HUNT: if (edge_evt) state_q <= ST_START;
        ST_START: if (decide_evt) begin
          if (bit_val) begin
            state_q <= ST_HUNT;
          end else begin
            state_q <= ST_DATA;
            shreg_q <= '0;
            got_q   <= '0;
            nbits_q <= bits_for(len_code);
            par_q   <= par_on;
            odd_q   <= par_odd;
            two_q   <= two_stop;
            drop_q  <= buf_full & ~rd_pulse;
          end
        end
        ST_DATA: if (decide_evt) begin
          shreg_q <= {bit_val, shreg_q[MAX_BITS-1:1]};
          got_q   <= got_q + 1'b1;
          if (got_q == nbits_q - 1'b1) state_q <= par_q ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (decide_evt) begin
          pbit_q  <= bit_val;
          state_q <= ST_STOP1;
        end
        ST_STOP1: if (decide_evt) state_q <= two_q ? ST_STOP2 : ST_HUNT;
        ST_STOP2: if (decide_evt) state_q <= ST_HUNT;
        default:  state_q <= ST_HUNT;
      endcase
    end
  end

  assign hunting   = (state_q == ST_HUNT);
  assign start_ok  = (state_q == ST_START) & decide_evt & ~bit_val;
  assign store_evt = (state_q == ST_STOP1) & decide_evt & ~drop_q;
  assign frm_data  = align_right(shreg_q, nbits_q);
  assign frm_ferr  = ~bit_val;
  assign frm_perr  = par_q & (pbit_q != parity_of(frm_data, odd_q));
endmodule

// File: rtl/srx_holdbuf.sv
module srx_holdbuf #(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                store_evt,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic                in_ferr,
  input  logic                in_perr,
  input  logic                start_ok,
  input  logic                rd_pulse,
  output logic                full,
  output logic [MAX_BITS-1:0] out_data,
  output logic                out_ferr,
  output logic                out_perr,
  output logic                out_ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
      out_ferr <= 1'b0;
      out_perr <= 1'b0;
      out_ovr  <= 1'b0;
    end else if (!enable) begin
      full     <= 1'b0;
      out_data <= '0;
      out_ferr <= 1'b0;
      out_perr <= 1'b0;
      out_ovr  <= 1'b0;
    end else if (store_evt) begin
      full     <= 1'b1;
      out_data <= in_data;
      out_ferr <= in_ferr;
      out_perr <= in_perr;
      out_ovr  <= 1'b0;
    end else if (rd_pulse) begin
      full     <= 1'b0;
      out_ferr <= 1'b0;
      out_perr <= 1'b0;
      out_ovr  <= 1'b0;
    end else if (start_ok && full) begin
      out_ovr  <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int VOTE_FIRST  = 8,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 9,
  parameter int LENW        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic                rx_line,
  input  logic                rx_on,
  input  logic [LENW-1:0]     len_code,
  input  logic [1:0]          par_mode,
  input  logic                two_stop,
  input  logic                rd_pulse,
  output logic [MAX_BITS-2:0] rd_data,
  output logic                rd_ext,
  output logic                full,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_overrun
);
  logic                line_s;
  logic                edge_evt, decide_evt, bit_val;
  logic                hunting, start_ok, store_evt;
  logic [MAX_BITS-1:0] frm_data, buf_data;
  logic                frm_ferr, frm_perr;

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  srx_sampler #(.OSR(OSR), .VOTE_FIRST(VOTE_FIRST)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line_s(line_s),
    .enable(rx_on), .hunting(hunting),
    .edge_evt(edge_evt), .decide_evt(decide_evt), .bit_val(bit_val)
  );

  srx_frame #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LENW(LENW)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable(rx_on),
    .edge_evt(edge_evt), .decide_evt(decide_evt), .bit_val(bit_val),
    .len_code(len_code), .par_on(par_mode[PAR_EN_BIT]), .par_odd(par_mode[PAR_ODD_BIT]),
    .two_stop(two_stop), .buf_full(full), .rd_pulse(rd_pulse),
    .hunting(hunting), .start_ok(start_ok), .store_evt(store_evt),
    .frm_data(frm_data), .frm_ferr(frm_ferr), .frm_perr(frm_perr)
  );

  srx_holdbuf #(.MAX_BITS(MAX_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(rx_on),
    .store_evt(store_evt), .in_data(frm_data), .in_ferr(frm_ferr), .in_perr(frm_perr),
    .start_ok(start_ok), .rd_pulse(rd_pulse),
    .full(full), .out_data(buf_data), .out_ferr(err_frame),
    .out_perr(err_parity), .out_ovr(err_overrun)
  );

  assign rd_data = buf_data[MAX_BITS-2:0];
  assign rd_ext  = buf_data[MAX_BITS-1];
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_on,
  input logic          rd_pulse,
  input logic          full,
  input logic          err_frame,
  input logic          err_parity,
  input logic          err_overrun,
  input logic [DW-2:0] rd_data,
  input logic          rd_ext,
  input logic          store_evt,
  input logic          start_ok
);
  AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> (!full && !err_frame && !err_parity && !err_overrun)) else $error("flush failed"); // R10

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && rd_pulse && !store_evt) |=> !full) else $error("read did not empty buffer"); // R7

  AST_STORE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && store_evt) |=> full) else $error("store did not fill buffer"); // R7

  AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && full && !rd_pulse) |=> (full && $stable(rd_data) && $stable(rd_ext))) else $error("unread data changed"); // R8

  AST_OVERRUN_ON_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && full && !rd_pulse && start_ok) |=> err_overrun) else $error("overrun not flagged"); // R8

  AST_FLAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity || err_overrun) |-> full) else $error("flag without data"); // R9
endmodule

bind serial_rx_core srx_checker #(.DW(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .rd_pulse(rd_pulse), .full(full),
  .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
  .rd_data(rd_data), .rd_ext(rd_ext), .store_evt(store_evt), .start_ok(start_ok)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BITCYC     = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick;
  logic       rx_line = 1'b1;
  logic       rx_on = 1'b0;
  logic [2:0] len_code = 3'd3;
  logic [1:0] par_mode = 2'b00;
  logic       two_stop = 1'b0;
  logic       rd_pulse = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ext, full, err_frame, err_parity, err_overrun;

  int n_checks = 0;
  int n_fail   = 0;
  int div      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) div <= (div == TDIV-1) ? 0 : div + 1;
  assign sample_tick = (div == TDIV-1);

  serial_rx_core dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .rx_on(rx_on), .len_code(len_code), .par_mode(par_mode), .two_stop(two_stop),
    .rd_pulse(rd_pulse), .rd_data(rd_data), .rd_ext(rd_ext), .full(full),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (BITCYC) @(negedge clk);
  endtask

  function automatic int nbits_of(input logic [2:0] code);
    return (code >= 3'd4) ? 9 : 5 + int'(code);
  endfunction

  // gbit >= 0 puts a one-tick inverted pulse near the centre of that data bit
  task automatic send_frame(input logic [8:0] d, input logic pflip, input logic s1,
                            input logic s2, input int gbit);
    int  n;
    logic p;
    n = nbits_of(len_code);
    p = par_mode[0];
    for (int i = 0; i < n; i++) p = p ^ d[i];
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      if (i == gbit) begin
        rx_line = d[i];  repeat (8*TDIV) @(negedge clk);
        rx_line = ~d[i]; repeat (TDIV)   @(negedge clk);
        rx_line = d[i];  repeat (7*TDIV) @(negedge clk);
      end else begin
        drive_bit(d[i]);
      end
    end
    if (par_mode[1]) drive_bit(p ^ pflip);
    drive_bit(s1);
    if (two_stop) drive_bit(s2);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic do_read();
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
  endtask

  task automatic expect_char(input string tag, input logic [8:0] d, input logic fe,
                             input logic pe, input logic ov);
    chk(tag, "full", full, 1'b1);
    chk(tag, "data", {rd_ext, rd_data}, d);
    chk(tag, "frame err", err_frame, fe);
    chk(tag, "parity err", err_parity, pe);
    chk(tag, "overrun", err_overrun, ov);
  endtask

  task automatic test_reset();
    chk("R1", "full", full, 1'b0);
    chk("R1", "flags", {err_frame, err_parity, err_overrun}, 3'b000);
  endtask

  task automatic test_lengths();
    logic [8:0] pats [5];
    pats[0] = 9'h015; pats[1] = 9'h02A; pats[2] = 9'h05B; pats[3] = 9'h0A5; pats[4] = 9'h1C3;
    par_mode = 2'b00; two_stop = 1'b0;
    for (int c = 0; c < 5; c++) begin
      len_code = 3'(c);
      send_frame(pats[c] | (9'h1FF << nbits_of(len_code)), 1'b0, 1'b1, 1'b1, -1);
      expect_char("R2", pats[c], 1'b0, 1'b0, 1'b0);
      repeat (2*BITCYC) @(negedge clk);
      chk("R7", "full held until read", full, 1'b1);
      do_read();
      chk("R7", "full after read", full, 1'b0);
    end
    len_code = 3'd7;
    send_frame(9'h13C, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R2", 9'h13C, 1'b0, 1'b0, 1'b0);
    do_read();
    len_code = 3'd3;
  endtask

  task automatic test_parity();
    len_code = 3'd3; two_stop = 1'b0;
    par_mode = 2'b10;
    send_frame(9'h0B7, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R5", 9'h0B7, 1'b0, 1'b0, 1'b0); do_read();
    send_frame(9'h0B7, 1'b1, 1'b1, 1'b1, -1);
    expect_char("R5", 9'h0B7, 1'b0, 1'b1, 1'b0); do_read();
    chk("R9", "parity flag gone after read", err_parity, 1'b0);
    par_mode = 2'b11;
    send_frame(9'h064, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R5", 9'h064, 1'b0, 1'b0, 1'b0); do_read();
    send_frame(9'h064, 1'b1, 1'b1, 1'b1, -1);
    expect_char("R5", 9'h064, 1'b0, 1'b1, 1'b0); do_read();
    par_mode = 2'b00;
    send_frame(9'h05A, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R9", 9'h05A, 1'b0, 1'b0, 1'b0); do_read();
  endtask

  task automatic test_frame();
    par_mode = 2'b00; len_code = 3'd3; two_stop = 1'b0;
    send_frame(9'h0C3, 1'b0, 1'b0, 1'b1, -1);
    expect_char("R6", 9'h0C3, 1'b1, 1'b0, 1'b0); do_read();
    two_stop = 1'b1;
    send_frame(9'h03C, 1'b0, 1'b1, 1'b0, -1);
    expect_char("R6", 9'h03C, 1'b0, 1'b0, 1'b0); do_read();
    two_stop = 1'b0;
  endtask

  task automatic test_false_start();
    rx_line = 1'b0; repeat (6*TDIV) @(negedge clk);
    rx_line = 1'b1; repeat (3*BITCYC) @(negedge clk);
    chk("R3", "rejected start stores nothing", full, 1'b0);
    send_frame(9'h096, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R3", 9'h096, 1'b0, 1'b0, 1'b0); do_read();
  endtask

  task automatic test_vote();
    send_frame(9'h0F0, 1'b0, 1'b1, 1'b1, 2);
    expect_char("R4", 9'h0F0, 1'b0, 1'b0, 1'b0); do_read();
    send_frame(9'h0F0, 1'b0, 1'b1, 1'b1, 6);
    expect_char("R4", 9'h0F0, 1'b0, 1'b0, 1'b0); do_read();
  endtask

  task automatic test_overrun();
    send_frame(9'h011, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R8", 9'h011, 1'b0, 1'b0, 1'b0);
    send_frame(9'h0EE, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R8", 9'h011, 1'b0, 1'b0, 1'b1);
    do_read();
    chk("R8", "overrun cleared by read", err_overrun, 1'b0);
    chk("R8", "second char discarded", full, 1'b0);
    send_frame(9'h077, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R9", 9'h077, 1'b0, 1'b0, 1'b0); do_read();
  endtask

  task automatic test_disable();
    send_frame(9'h0AB, 1'b0, 1'b0, 1'b1, -1);
    expect_char("R10", 9'h0AB, 1'b1, 1'b0, 1'b0);
    rx_on = 1'b0;
    @(negedge clk);
    chk("R10", "full after flush", full, 1'b0);
    chk("R10", "flags after flush", {err_frame, err_parity, err_overrun}, 3'b000);
    send_frame(9'h055, 1'b0, 1'b1, 1'b1, -1);
    rx_on = 1'b1;
    repeat (2*BITCYC) @(negedge clk);
    chk("R10", "frame while disabled not received", full, 1'b0);
    send_frame(9'h0D2, 1'b0, 1'b1, 1'b1, -1);
    expect_char("R10", 9'h0D2, 1'b0, 1'b0, 1'b0); do_read();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    rx_on = 1'b1;
    repeat (2*BITCYC) @(negedge clk);
    test_lengths();
    test_parity();
    test_frame();
    test_false_start();
    test_vote();
    test_overrun();
    test_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule